// File: doc/BRIEF.md
# Broadcast/Multicast Ingress Rate Limiter

This block caps how many broadcast and how many multicast frames each ingress port may accept within a repeating time window. A shared prescaler splits the clock into windows of a programmable number of cycles. Each port keeps one counter for broadcast traffic and one for multicast traffic, and each counter has its own 8-bit limit. The parser in front of the block raises a one-cycle arrival strobe per port, with qualifiers that mark the frame as broadcast or multicast. One cycle later the block returns a per-port decision that says whether to accept or drop that frame.

All counters clear together whenever the prescaler wraps. A counter that has reached its limit causes later frames of its class on its port to be dropped until the next window begins. A limit of zero leaves that class on that port unrestricted. A global enable bypasses all limiting. With the prescale set to the clock frequency divided by 1000, the window is 1 ms, so the admitted rate is limit × 1000 frames per second.

Top module: `bcmc_rate_limiter`

## Requirements
- R1: After reset, no decision is flagged, every limit is 0 (unlimited) and the prescale is 16 cycles.
- R2: A frame strobed on `frm_valid_i[p]` yields `dec_valid_o[p]` high exactly one cycle later. `dec_drop_o[p]` is high only together with `dec_valid_o[p]`.
- R3: With limit L > 0, the first L frames of a class on a port in one window are accepted and later ones in that window are dropped. A dropped frame does not advance its counter.
- R4: A limit of 0 means no frame of that class on that port is ever dropped.
- R5: A frame with `frm_bcast_i` set counts only against the broadcast limit, even when `frm_mcast_i` is also set. A frame with neither qualifier is always accepted.
- R6: The broadcast and multicast counters of a port are independent of each other, and every port is independent of the other ports.
- R7: The prescaler clears every counter once every P cycles. A frame sampled on the last cycle of a window is judged against that window, and the frame that follows starts the new window from a count of zero.
- R8: A prescale write takes the value `max(cfg_presc_i, 16)`. It restarts the prescaler and clears all counters, and the clock edge that takes the write begins a window of P cycles.
- R9: While `enable_i` is low, every frame is accepted and no counter advances.
- R10: Limits span 1 to 255. With a limit of 255, 255 frames are accepted and the 256th in the same window is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global rate-limit enable |
| cfg_presc_we_i | input | 1 | Prescale write strobe |
| cfg_presc_i | input | 19 | Prescale value in cycles (floor 16) |
| cfg_lim_we_i | input | 1 | Limit write strobe |
| cfg_lim_port_i | input | 2 | Port selected by the limit write |
| cfg_lim_mcast_i | input | 1 | Limit write target: 0 broadcast, 1 multicast |
| cfg_lim_val_i | input | 8 | Limit value, 0 = unlimited |
| frm_valid_i | input | 4 | Per-port frame arrival strobe |
| frm_bcast_i | input | 4 | Per-port broadcast qualifier |
| frm_mcast_i | input | 4 | Per-port multicast qualifier |
| dec_valid_o | output | 4 | Per-port decision valid, one cycle after the strobe |
| dec_drop_o | output | 4 | Per-port drop decision |

## Verification
The assertions assume that the qualifiers are meaningful only while the arrival strobe is high, and that a port strobes at most one frame per cycle. They also assume that configuration writes are single-cycle pulses. The bench drives every input on the falling edge, raises each strobe for exactly one cycle per frame, and issues each write as a one-cycle pulse outside the frame stimulus. Window boundaries are checked by counting clock edges from the prescale write that opened the window. Each boundary test places a frame exactly on the wrap edge and another one edge later.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef enum logic {
    CLS_BCAST = 1'b0,
    CLS_MCAST = 1'b1
  } rl_class_e;

  localparam int unsigned NUM_CLASSES = 2;
endpackage

// File: rtl/rl_prescaler.sv
module rl_prescaler #(
  parameter int unsigned PRESC_W   = 19,
  parameter int unsigned PRESC_MIN = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PRESC_W-1:0] val_i,
  output logic               tick_o
);
  localparam logic [PRESC_W-1:0] MIN_V = PRESC_W'(PRESC_MIN);

  logic [PRESC_W-1:0] presc_q, cnt_q, presc_d;

  assign presc_d = (val_i < MIN_V) ? MIN_V : val_i;
  assign tick_o  = (cnt_q == presc_q - PRESC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= MIN_V;
      cnt_q   <= '0;
    end else if (we_i) begin
      presc_q <= presc_d;
      cnt_q   <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PRESC_W'(1);
    end
  end

  // R8
  presc_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_q >= MIN_V);
  // R7
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < presc_q);
  // R7
  wrap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);
  // R8
  write_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_q == '0) && (presc_q >= MIN_V));
endmodule

// File: rtl/rl_class_ctr.sv
module rl_class_ctr #(
  parameter int unsigned LIMIT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic               lim_we_i,
  input  logic [LIMIT_W-1:0] lim_i,
  input  logic               hit_i,
  output logic               drop_o
);
  logic [LIMIT_W-1:0] lim_q, cnt_q;
  logic               limited, take;

  assign limited = en_i && (lim_q != '0);
  assign drop_o  = limited && (cnt_q >= lim_q);
  assign take    = hit_i && limited && !drop_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else begin
      if (lim_we_i) lim_q <= lim_i;
      if (clr_i)     cnt_q <= '0;
      else if (take) cnt_q <= cnt_q + LIMIT_W'(1);
    end
  end

  // R3
  drop_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && drop_o && !clr_i) |=> $stable(cnt_q));
  // R9
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  // R7
  window_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  // R4
  zero_unlimited_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_q == '0) |-> !drop_o);
endmodule

// File: rtl/bcmc_rate_limiter.sv
module bcmc_rate_limiter #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned LIMIT_W   = 8,
  parameter int unsigned PRESC_W   = 19,
  parameter int unsigned PRESC_MIN = 16,
  localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enable_i,
  input  logic                 cfg_presc_we_i,
  input  logic [PRESC_W-1:0]   cfg_presc_i,
  input  logic                 cfg_lim_we_i,
  input  logic [PORT_W-1:0]    cfg_lim_port_i,
  input  logic                 cfg_lim_mcast_i,
  input  logic [LIMIT_W-1:0]   cfg_lim_val_i,
  input  logic [NUM_PORTS-1:0] frm_valid_i,
  input  logic [NUM_PORTS-1:0] frm_bcast_i,
  input  logic [NUM_PORTS-1:0] frm_mcast_i,
  output logic [NUM_PORTS-1:0] dec_valid_o,
  output logic [NUM_PORTS-1:0] dec_drop_o
);
  import rl_pkg::*;

  logic tick, clr;
  logic [NUM_PORTS-1:0] drop_d, valid_q, drop_q;

  rl_prescaler #(.PRESC_W(PRESC_W), .PRESC_MIN(PRESC_MIN)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_presc_we_i),
    .val_i  (cfg_presc_i),
    .tick_o (tick)
  );

  // a prescale write opens a fresh window just like a wrap
  assign clr = tick || cfg_presc_we_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [NUM_CLASSES-1:0] hit, cls_drop;

    // broadcast wins when both qualifiers are set
    assign hit[CLS_BCAST] = frm_valid_i[p] && frm_bcast_i[p];
    assign hit[CLS_MCAST] = frm_valid_i[p] && frm_mcast_i[p] && !frm_bcast_i[p];

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
      logic lim_we;
      assign lim_we = cfg_lim_we_i && (cfg_lim_port_i == PORT_W'(p))
                      && (cfg_lim_mcast_i == 1'(c));

      rl_class_ctr #(.LIMIT_W(LIMIT_W)) u_ctr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (enable_i),
        .clr_i    (clr),
        .lim_we_i (lim_we),
        .lim_i    (cfg_lim_val_i),
        .hit_i    (hit[c]),
        .drop_o   (cls_drop[c])
      );
    end

    assign drop_d[p] = |(hit & cls_drop);

    // R2
    drop_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_drop_o[p] |-> dec_valid_o[p]);
    // R2
    one_cycle_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frm_valid_i[p] |=> dec_valid_o[p]);
    // R5
    unicast_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_valid_i[p] && !frm_bcast_i[p] && !frm_mcast_i[p]) |=> !dec_drop_o[p]);
    // R9
    bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_valid_i[p] && !enable_i) |=> !dec_drop_o[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      drop_q  <= '0;
    end else begin
      valid_q <= frm_valid_i;
      drop_q  <= drop_d;
    end
  end

  assign dec_valid_o = valid_q;
  assign dec_drop_o  = drop_q;
endmodule

// File: tb/sim_bcmc_rate_limiter.sv
module sim_bcmc_rate_limiter;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b1;
  logic        cfg_presc_we_i = 1'b0;
  logic [18:0] cfg_presc_i = '0;
  logic        cfg_lim_we_i = 1'b0;
  logic [1:0]  cfg_lim_port_i = '0;
  logic        cfg_lim_mcast_i = 1'b0;
  logic [7:0]  cfg_lim_val_i = '0;
  logic [3:0]  frm_valid_i = '0, frm_bcast_i = '0, frm_mcast_i = '0;
  logic [3:0]  dec_valid_o, dec_drop_o;

  int tests = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcmc_rate_limiter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i),
    .cfg_presc_we_i(cfg_presc_we_i), .cfg_presc_i(cfg_presc_i),
    .cfg_lim_we_i(cfg_lim_we_i), .cfg_lim_port_i(cfg_lim_port_i),
    .cfg_lim_mcast_i(cfg_lim_mcast_i), .cfg_lim_val_i(cfg_lim_val_i),
    .frm_valid_i(frm_valid_i), .frm_bcast_i(frm_bcast_i), .frm_mcast_i(frm_mcast_i),
    .dec_valid_o(dec_valid_o), .dec_drop_o(dec_drop_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG_CYCLES) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge; each consumes whole cycles
  task automatic set_lim(input int port, input bit mc, input int val);
    cfg_lim_we_i = 1'b1; cfg_lim_port_i = 2'(port);
    cfg_lim_mcast_i = mc; cfg_lim_val_i = 8'(val);
    @(negedge clk);
    cfg_lim_we_i = 1'b0;
  endtask

  task automatic restart(input int presc);
    cfg_presc_we_i = 1'b1; cfg_presc_i = 19'(presc);
    @(negedge clk);
    cfg_presc_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int port, input bit b, input bit m,
                      input bit exp_drop, input string tag);
    frm_valid_i = '0; frm_bcast_i = '0; frm_mcast_i = '0;
    frm_valid_i[port] = 1'b1; frm_bcast_i[port] = b; frm_mcast_i[port] = m;
    @(negedge clk);
    frm_valid_i = '0; frm_bcast_i = '0; frm_mcast_i = '0;
    check({tag, " valid"}, int'(dec_valid_o[port]), 1);
    check({tag, " drop"}, int'(dec_drop_o[port]), int'(exp_drop));
  endtask

  task automatic t_reset;
    check("R1 valid idle", int'(dec_valid_o), 0);
    check("R1 drop idle", int'(dec_drop_o), 0);
    for (int i = 0; i < 3; i++) send(0, 1'b1, 1'b0, 1'b0, "R1 default unlimited");
    idle(2);
    check("R2 no strobe no decision", int'(dec_valid_o), 0);
  endtask

  task automatic t_limits;
    set_lim(0, 1'b0, 3); set_lim(0, 1'b1, 2);
    set_lim(2, 1'b0, 1); set_lim(2, 1'b1, 5);
    restart(1000);
    for (int i = 0; i < 3; i++) send(0, 1'b1, 1'b0, 1'b0, "R3 bcast under limit");
    send(0, 1'b1, 1'b0, 1'b1, "R3 bcast at limit");
    send(0, 1'b1, 1'b0, 1'b1, "R3 bcast stays dropped");
    send(0, 1'b0, 1'b1, 1'b0, "R6 mcast independent");
    send(0, 1'b0, 1'b1, 1'b0, "R6 mcast independent");
    send(0, 1'b0, 1'b1, 1'b1, "R6 mcast own limit");
    for (int i = 0; i < 10; i++) send(1, 1'b1, 1'b0, 1'b0, "R4 zero limit");
    send(2, 1'b1, 1'b1, 1'b0, "R5 both flags first");
    send(2, 1'b1, 1'b1, 1'b1, "R5 both flags bcast full");
    for (int i = 0; i < 5; i++) send(2, 1'b0, 1'b1, 1'b0, "R5 mcast untouched");
    send(2, 1'b0, 1'b1, 1'b1, "R5 mcast at limit");
    send(0, 1'b0, 1'b0, 1'b0, "R5 unicast passes");
    send(3, 1'b1, 1'b0, 1'b0, "R6 other port free");
  endtask

  task automatic t_window;
    set_lim(3, 1'b0, 2);
    restart(40);
    send(3, 1'b1, 1'b0, 1'b0, "R7 k1");
    send(3, 1'b1, 1'b0, 1'b0, "R7 k2");
    send(3, 1'b1, 1'b0, 1'b1, "R7 k3 full");
    idle(36);
    send(3, 1'b1, 1'b0, 1'b1, "R7 last cycle old window");
    send(3, 1'b1, 1'b0, 1'b0, "R7 new window first");
    send(3, 1'b1, 1'b0, 1'b0, "R7 new window second");
    send(3, 1'b1, 1'b0, 1'b1, "R7 new window full");
  endtask

  task automatic t_floor;
    set_lim(3, 1'b0, 1);
    restart(3);
    send(3, 1'b1, 1'b0, 1'b0, "R8 k1");
    send(3, 1'b1, 1'b0, 1'b1, "R8 k2 full");
    idle(13);
    send(3, 1'b1, 1'b0, 1'b1, "R8 floor window end");
    send(3, 1'b1, 1'b0, 1'b0, "R8 floor new window");
  endtask

  task automatic t_enable;
    set_lim(3, 1'b0, 2);
    restart(1000);
    enable_i = 1'b0;
    send(3, 1'b1, 1'b0, 1'b0, "R9 bypass");
    send(3, 1'b1, 1'b0, 1'b0, "R9 bypass");
    send(3, 1'b1, 1'b0, 1'b0, "R9 bypass");
    enable_i = 1'b1;
    send(3, 1'b1, 1'b0, 1'b0, "R9 no count while off");
    send(3, 1'b1, 1'b0, 1'b0, "R9 no count while off");
    send(3, 1'b1, 1'b0, 1'b1, "R9 limit after re-enable");
  endtask

  task automatic t_max;
    int acc = 0;
    set_lim(1, 1'b1, 255);
    restart(1000);
    for (int i = 0; i < 255; i++) begin
      frm_valid_i[1] = 1'b1; frm_mcast_i[1] = 1'b1;
      @(negedge clk);
      frm_valid_i = '0; frm_mcast_i = '0;
      if (dec_valid_o[1] && !dec_drop_o[1]) acc++;
    end
    check("R10 255 accepted", acc, 255);
    send(1, 1'b0, 1'b1, 1'b1, "R10 256th dropped");
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_limits();
    t_window();
    t_floor();
    t_enable();
    t_max();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule